// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Status Flags

This block performs the additive arithmetic group of a processor datapath: add, add with carry-in, increment, subtract, subtract with borrow-in, decrement and two's-complement negate, on 8-, 16- or 32-bit operands chosen per operation. Along with the result it produces six status flags: carry, parity, auxiliary (nibble) carry, zero, sign and overflow. For each flag it also gives a write-enable that tells a downstream flag register whether that operation is allowed to change the flag.

All seven operations share one adder. The operation code selects how the two operands and the carry-in are conditioned before they reach the adder. The size select picks the bit position where carry, sign, zero and overflow are read. Result and flags are captured in output registers, so they appear one clock after the inputs are presented. When the size is byte or word, the result bits above that width are the destination operand's own bits, so a caller can write the full register back unchanged.

Top module: `alu_flags_top`

## Requirements
- R1: Operation code 0 gives dst+src and code 1 gives dst+src+cf_i, both at the selected width. The carry flag is the carry out of the width's top bit.
- R2: Operation code 3 gives dst-src and code 4 gives dst-src-cf_i. The carry flag is 1 exactly when the unsigned destination is less than src plus the borrow-in.
- R3: Operation code 2 gives dst+1 and code 5 gives dst-1. For both, the carry write-enable is 0 and the carry flag output equals cf_i, while the other five flags are computed and enabled.
- R4: Operation code 6 gives 0-dst. Its carry is 1 for any non-zero operand and 0 for zero. The most negative value at the width returns unchanged with overflow set.
- R5: Size select 0 is byte, 1 is word, and 2 or 3 is doubleword. At byte and word size, result bits above the width equal the matching bits of dst_i.
- R6: The auxiliary flag is the carry out of bit 3 for additions and the borrow out of bit 3 for subtractions and negate.
- R7: The sign flag is the top bit of the result at the selected width. The zero flag is 1 when every result bit within that width is 0.
- R8: The parity flag is 1 when bits 7..0 of the result hold an even number of ones, whatever the size.
- R9: The overflow flag is set when the two adder inputs (the source inverted for subtraction) have the same sign and the result sign differs from it.
- R10: Codes 0, 1, 3, 4 and 6 enable all six flags. Code 7 is reserved: the result equals dst_i, and all flags and all write-enables are 0.
- R11: Flag bit positions in flags_o and flag_we_o are 0 carry, 1 parity, 2 auxiliary, 3 zero, 4 sign and 5 overflow. Outputs are registered with one clock of latency, and a synchronous active-high reset clears them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code |
| size_i | input | 2 | Operand width select |
| dst_i | input | DATA_W | Destination operand (first operand) |
| src_i | input | DATA_W | Source operand |
| cf_i | input | 1 | Incoming carry flag |
| res_o | output | DATA_W | Registered result |
| flags_o | output | 6 | Registered flag values |
| flag_we_o | output | 6 | Registered per-flag write-enables |

## Verification
Uniform random operands almost never reach the cases that matter most. These are negate of the most negative value at a narrow width, borrow-in pushing a subtraction from zero to a borrow, and a nibble carry when the word carry is absent. Directed vectors place each of these at byte, word and doubleword size, with non-zero upper destination bits so that pass-through is visible. Random vectors then mix every code, including the reserved one, with operands drawn from a small pool of edge patterns as well as free values.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_INC = 3'd2,
    OP_SUB = 3'd3,
    OP_SBB = 3'd4,
    OP_DEC = 3'd5,
    OP_NEG = 3'd6,
    OP_RSV = 3'd7
  } alu_op_e;

  localparam int NFLAG  = 6;
  localparam int NSIZE  = 3;
  localparam int FL_CF  = 0;
  localparam int FL_PF  = 1;
  localparam int FL_AF  = 2;
  localparam int FL_ZF  = 3;
  localparam int FL_SF  = 4;
  localparam int FL_OF  = 5;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } alu_flags_t;

endpackage

// File: rtl/alu_opnd_prep.sv
module alu_opnd_prep
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] dst,
  input  logic [W-1:0] src,
  input  logic         cf_in,
  output logic [W-1:0] add_a,
  output logic [W-1:0] add_b,
  output logic         add_cin,
  output logic         is_sub,
  output logic         keep_cf,
  output logic         op_ok
);

  alu_op_e op_e;
  assign op_e = alu_op_e'(op);

  // Subtraction is done as a + ~b + (1 - borrow); carry is inverted afterwards.
  always_comb begin
    add_a   = dst;
    add_b   = src;
    add_cin = 1'b0;
    is_sub  = 1'b0;
    keep_cf = 1'b0;
    op_ok   = 1'b1;
    unique case (op_e)
      OP_ADD: ;
      OP_ADC: add_cin = cf_in;
      OP_INC: begin
        add_b   = '0;
        add_cin = 1'b1;
        keep_cf = 1'b1;
      end
      OP_SUB: begin
        add_b   = ~src;
        add_cin = 1'b1;
        is_sub  = 1'b1;
      end
      OP_SBB: begin
        add_b   = ~src;
        add_cin = ~cf_in;
        is_sub  = 1'b1;
      end
      OP_DEC: begin
        add_b   = ~W'(1);
        add_cin = 1'b1;
        is_sub  = 1'b1;
        keep_cf = 1'b1;
      end
      OP_NEG: begin
        add_a   = '0;
        add_b   = ~dst;
        add_cin = 1'b1;
        is_sub  = 1'b1;
      end
      default: op_ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_carry_core.sv
module alu_carry_core
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic             cin,
  output logic [W-1:0]     sum,
  output logic [NSIZE-1:0] cout_sz,
  output logic [NSIZE-1:0] ovf_sz,
  output logic             c4
);

  localparam int XW = W + 1;

  logic [XW-1:0] a_x, b_x, full;

  assign a_x  = {1'b0, a};
  assign b_x  = {1'b0, b};
  assign full = a_x + b_x + XW'(cin);
  assign sum  = full[W-1:0];

  // Carry into bit k is recovered as full[k] ^ a[k] ^ b[k].
  assign c4 = full[4] ^ a_x[4] ^ b_x[4];

  for (genvar g = 0; g < NSIZE; g++) begin : g_width
    localparam int SW = W >> (NSIZE - 1 - g);
    assign cout_sz[g] = full[SW] ^ a_x[SW] ^ b_x[SW];
    assign ovf_sz[g]  = (a_x[SW-1] == b_x[SW-1]) && (full[SW-1] != a_x[SW-1]);
  end

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]       size,
  input  logic [W-1:0]     sum,
  input  logic [W-1:0]     dst,
  input  logic [NSIZE-1:0] cout_sz,
  input  logic [NSIZE-1:0] ovf_sz,
  input  logic             c4,
  input  logic             is_sub,
  input  logic             keep_cf,
  input  logic             op_ok,
  input  logic             cf_in,
  output logic [W-1:0]     res,
  output alu_flags_t       flags,
  output logic [NFLAG-1:0] we
);

  logic [W-1:0]     mask_sz [NSIZE];
  logic [NSIZE-1:0] sgn_sz;
  logic [NSIZE-1:0] zro_sz;
  logic [1:0]       idx;

  for (genvar g = 0; g < NSIZE; g++) begin : g_width
    localparam int SW = W >> (NSIZE - 1 - g);
    assign mask_sz[g] = {W{1'b1}} >> (W - SW);
    assign sgn_sz[g]  = sum[SW-1];
    assign zro_sz[g]  = (sum[SW-1:0] == '0);
  end

  assign idx = (size >= 2'd2) ? 2'd2 : size;

  always_comb begin
    res   = dst;
    flags = '0;
    we    = '0;
    if (op_ok) begin
      res      = (sum & mask_sz[idx]) | (dst & ~mask_sz[idx]);
      flags.cf = keep_cf ? cf_in : (cout_sz[idx] ^ is_sub);
      flags.pf = ~^sum[7:0];
      flags.af = c4 ^ is_sub;
      flags.zf = zro_sz[idx];
      flags.sf = sgn_sz[idx];
      flags.of = ovf_sz[idx];
      we        = '1;
      we[FL_CF] = ~keep_cf;
    end
  end

endmodule

// File: rtl/alu_flags_top.sv
module alu_flags_top
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic              cf_i,
  output logic [DATA_W-1:0] res_o,
  output logic [NFLAG-1:0]  flags_o,
  output logic [NFLAG-1:0]  flag_we_o
);

  logic [DATA_W-1:0] add_a, add_b, sum, res_n;
  logic              add_cin, is_sub, keep_cf, op_ok, c4;
  logic [NSIZE-1:0]  cout_sz, ovf_sz;
  alu_flags_t        flags_n;
  logic [NFLAG-1:0]  we_n;

  alu_opnd_prep #(.W(DATA_W)) u_prep (
    .op(op_i), .dst(dst_i), .src(src_i), .cf_in(cf_i),
    .add_a(add_a), .add_b(add_b), .add_cin(add_cin),
    .is_sub(is_sub), .keep_cf(keep_cf), .op_ok(op_ok)
  );

  alu_carry_core #(.W(DATA_W)) u_core (
    .a(add_a), .b(add_b), .cin(add_cin), .sum(sum),
    .cout_sz(cout_sz), .ovf_sz(ovf_sz), .c4(c4)
  );

  alu_flag_gen #(.W(DATA_W)) u_flags (
    .size(size_i), .sum(sum), .dst(dst_i), .cout_sz(cout_sz),
    .ovf_sz(ovf_sz), .c4(c4), .is_sub(is_sub), .keep_cf(keep_cf),
    .op_ok(op_ok), .cf_in(cf_i), .res(res_n), .flags(flags_n), .we(we_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o     <= '0;
      flags_o   <= '0;
      flag_we_o <= '0;
    end else begin
      res_o     <= res_n;
      flags_o   <= flags_n;
      flag_we_o <= we_n;
    end
  end

endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        op_i,
  input logic [1:0]        size_i,
  input logic [DATA_W-1:0] dst_i,
  input logic              cf_i,
  input logic [DATA_W-1:0] res_o,
  input logic [NFLAG-1:0]  flags_o,
  input logic [NFLAG-1:0]  flag_we_o
);

  logic              prev_ok;
  logic [2:0]        prev_op;
  logic [1:0]        prev_size;
  logic [DATA_W-1:0] prev_dst;
  logic              prev_cf;
  logic [DATA_W-1:0] pmask, pmin;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_ok   <= 1'b0;
      prev_op   <= '0;
      prev_size <= '0;
      prev_dst  <= '0;
      prev_cf   <= 1'b0;
    end else begin
      prev_ok   <= 1'b1;
      prev_op   <= op_i;
      prev_size <= size_i;
      prev_dst  <= dst_i;
      prev_cf   <= cf_i;
    end
  end

  always_comb begin
    case (prev_size)
      2'd0:    pmask = DATA_W'({8{1'b1}}) << 0 >> 0 & ({DATA_W{1'b1}} >> (DATA_W - DATA_W/4));
      2'd1:    pmask = {DATA_W{1'b1}} >> (DATA_W - DATA_W/2);
      default: pmask = {DATA_W{1'b1}};
    endcase
    pmin = (pmask >> 1) + DATA_W'(1);
  end

  a_r3_carry_untouched: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && (prev_op == OP_INC || prev_op == OP_DEC))
      |-> (!flag_we_o[FL_CF] && flags_o[FL_CF] == prev_cf));

  a_r4_neg_carry: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && prev_op == OP_NEG)
      |-> (flags_o[FL_CF] == ((prev_dst & pmask) != '0)));

  a_r9_neg_min_overflow: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && prev_op == OP_NEG && (prev_dst & pmask) == pmin)
      |-> (flags_o[FL_OF] && (res_o & pmask) == pmin));

  a_r5_upper_pass: assert property (@(posedge clk) disable iff (rst)
    prev_ok |-> ((res_o & ~pmask) == (prev_dst & ~pmask)));

  a_r7_zero: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && flag_we_o[FL_ZF]) |-> (flags_o[FL_ZF] == ((res_o & pmask) == '0)));

  a_r7_sign: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && flag_we_o[FL_SF]) |-> (flags_o[FL_SF] == ((res_o & pmin) != '0)));

  a_r8_parity: assert property (@(posedge clk) disable iff (rst)
    flag_we_o[FL_PF] |-> (flags_o[FL_PF] == ~^res_o[7:0]));

  a_r6_inc_nibble: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && prev_op == OP_INC && prev_dst[3:0] == 4'hF) |-> flags_o[FL_AF]);

  a_r10_reserved: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && prev_op == OP_RSV)
      |-> (flag_we_o == '0 && flags_o == '0 && res_o == prev_dst));

endmodule

bind alu_flags_top alu_flags_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .size_i(size_i), .dst_i(dst_i),
  .cf_i(cf_i), .res_o(res_o), .flags_o(flags_o), .flag_we_o(flag_we_o)
);

// File: tb/alu_flags_top_tb.sv
module alu_flags_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 32;
  localparam int N_RANDOM   = 800;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   op_i = '0;
  logic [1:0]   size_i = '0;
  logic [W-1:0] dst_i = '0;
  logic [W-1:0] src_i = '0;
  logic         cf_i = 1'b0;
  logic [W-1:0] res_o;
  logic [5:0]   flags_o;
  logic [5:0]   flag_we_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_flags_top #(.DATA_W(W)) u_dut (
    .clk(clk), .rst(rst), .op_i(op_i), .size_i(size_i), .dst_i(dst_i),
    .src_i(src_i), .cf_i(cf_i), .res_o(res_o), .flags_o(flags_o),
    .flag_we_o(flag_we_o)
  );

  function automatic longint sext(input longint v, input int w);
    if (((v >> (w - 1)) & 64'd1) != 0) return v - (longint'(1) << w);
    return v;
  endfunction

  // Reference built from the requirements: plain integer arithmetic.
  task automatic model(input logic [2:0] op, input logic [1:0] sz,
                       input logic [W-1:0] d_in, input logic [W-1:0] s_in,
                       input logic c_in, output logic [W-1:0] r_out,
                       output logic [5:0] f_out, output logic [5:0] we_out);
    int w;
    longint m, d, s, x, y, c, u, r, sr, hi, lo;
    logic cf, af, ov;
    w  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m  = (longint'(1) << w) - 1;
    d  = longint'(d_in) & m;
    s  = longint'(s_in) & m;
    hi = (longint'(1) << (w - 1)) - 1;
    lo = -(longint'(1) << (w - 1));
    if (op == 3'd7) begin
      r_out = d_in; f_out = '0; we_out = '0;
      return;
    end
    if (op <= 3'd2) begin
      x  = d;
      y  = (op == 3'd2) ? 1 : s;
      c  = (op == 3'd1) ? longint'(c_in) : 0;
      u  = x + y + c;
      r  = u & m;
      cf = (u > m);
      af = ((x & 15) + (y & 15) + c) > 15;
      sr = sext(x, w) + sext(y, w) + c;
    end else begin
      x  = (op == 3'd6) ? 0 : d;
      y  = (op == 3'd6) ? d : (op == 3'd5) ? 1 : s;
      c  = (op == 3'd4) ? longint'(c_in) : 0;
      r  = (x - y - c) & m;
      cf = (x < y + c);
      af = ((x & 15) < (y & 15) + c);
      sr = sext(x, w) - sext(y, w) - c;
    end
    ov = (sr > hi) || (sr < lo);
    if (op == 3'd2 || op == 3'd5) cf = c_in;
    r_out = W'(r) | (d_in & ~W'(m));
    f_out[0] = cf;
    f_out[1] = ~^r[7:0];
    f_out[2] = af;
    f_out[3] = (r == 0);
    f_out[4] = ((r >> (w - 1)) & 1) != 0;
    f_out[5] = ov;
    we_out = 6'h3F;
    if (op == 3'd2 || op == 3'd5) we_out[0] = 1'b0;
  endtask

  task automatic apply(input logic [2:0] op, input logic [1:0] sz,
                       input logic [W-1:0] d, input logic [W-1:0] s,
                       input logic c, input string tag);
    logic [W-1:0] er;
    logic [5:0]   ef, ew;
    @(negedge clk);
    op_i = op; size_i = sz; dst_i = d; src_i = s; cf_i = c;
    @(negedge clk);
    model(op, sz, d, s, c, er, ef, ew);
    n_vec++;
    if (res_o !== er || flags_o !== ef || flag_we_o !== ew) begin
      n_bad++;
      $display("FAIL %s op=%0d sz=%0d d=%h s=%h c=%0b: res/flags/we got %h/%b/%b exp %h/%b/%b",
               tag, op, sz, d, s, c, res_o, flags_o, flag_we_o, er, ef, ew);
    end
  endtask

  function automatic logic [W-1:0] pick_operand();
    case ($urandom % 6)
      0: return '0;
      1: return '1;
      2: return 32'h8000_0080;
      3: return 32'h7FFF_7F7F;
      4: return 32'h0000_800F;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5EED_1234));
    op_i = 3'd0; dst_i = 32'hFFFF_FFFF; src_i = 32'h1; cf_i = 1'b1;
    repeat (3) @(negedge clk);
    n_vec++;
    if (res_o !== '0 || flags_o !== '0 || flag_we_o !== '0) begin
      n_bad++;
      $display("FAIL R11 reset: got %h/%b/%b exp 0/0/0", res_o, flags_o, flag_we_o);
    end
    rst = 1'b0;

    // R1 and R8: word add, 1100+0ABC -> 1BBC, odd parity
    apply(3'd0, 2'd1, 32'hAAAA_1100, 32'h0000_0ABC, 1'b0, "R1 R8 word add");
    apply(3'd1, 2'd0, 32'h0000_00AB, 32'h0000_0005, 1'b1, "R1 adc byte");
    apply(3'd0, 2'd2, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, "R1 dword wrap");
    // R2: borrow cases
    apply(3'd4, 2'd1, 32'h0000_1234, 32'h0000_0123, 1'b0, "R2 sbb no borrow");
    apply(3'd4, 2'd0, 32'h1234_5600, 32'h0000_0000, 1'b1, "R2 sbb borrow-in only");
    apply(3'd3, 2'd2, 32'h0000_0000, 32'h0000_0001, 1'b0, "R2 sub 0-1");
    // R3: carry preserved across inc/dec
    apply(3'd2, 2'd0, 32'h0000_00FF, 32'h0, 1'b0, "R3 inc byte wrap");
    apply(3'd5, 2'd1, 32'h0000_0000, 32'h0, 1'b1, "R3 dec word underflow");
    apply(3'd2, 2'd0, 32'h0000_000F, 32'h0, 1'b1, "R3 R6 inc nibble");
    // R4: negate
    apply(3'd6, 2'd1, 32'h0000_003A, 32'h0, 1'b0, "R4 neg 003A");
    apply(3'd6, 2'd2, 32'h0000_0000, 32'h0, 1'b1, "R4 neg zero");
    apply(3'd6, 2'd0, 32'hDEAD_BE80, 32'h0, 1'b0, "R4 R5 neg byte min");
    apply(3'd6, 2'd2, 32'h8000_0000, 32'h0, 1'b0, "R4 neg dword min");
    // R5: pass-through of upper bits, size 3 acts as dword
    apply(3'd0, 2'd0, 32'h1357_9BFF, 32'hFFFF_FF01, 1'b0, "R5 byte upper pass");
    apply(3'd3, 2'd3, 32'h0000_0010, 32'h0000_0011, 1'b0, "R5 size3 dword");
    // R6: nibble carry without word carry
    apply(3'd0, 2'd1, 32'h0000_0008, 32'h0000_0008, 1'b0, "R6 nibble carry");
    apply(3'd3, 2'd0, 32'h0000_0010, 32'h0000_0001, 1'b0, "R6 nibble borrow");
    // R7 / R9: signed overflow both directions
    apply(3'd0, 2'd0, 32'h0000_007F, 32'h0000_0001, 1'b0, "R7 R9 byte +ovf");
    apply(3'd3, 2'd1, 32'h0000_8000, 32'h0000_0001, 1'b0, "R9 word -ovf");
    // R10: reserved code
    apply(3'd7, 2'd1, 32'hCAFE_F00D, 32'h1111_1111, 1'b1, "R10 reserved");

    for (int i = 0; i < N_RANDOM; i++) begin
      apply(3'($urandom % 8), 2'($urandom % 4), pick_operand(), pick_operand(),
            1'($urandom % 2), "R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R11 watchdog expired: got hang exp completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule